// File: doc/BRIEF.md
# Debug Transmit Mailbox with Scan Readout

This block lets software on the core pass 32-bit words out to an external debugger through a JTAG test access port. Software writes a word into a transmit holding register in the core clock domain. The write raises a pending flag, which software sees at bit 28 of a read-only status word. The flag crosses into the TCK domain. When the TAP has this data register selected, a capture strobe takes a 36-bit snapshot of the word and the flag. Shift strobes then move the snapshot out on `tdo`.

The debugger learns from scan bit 0 whether the word it read was new. The first shift after a capture that saw the flag set counts as the debugger's read. That read sends a clear request back into the core domain through a toggle and a two-flop synchroniser. If a software write lands in the same core cycle as the clear, the write wins and the new word stays pending. Data shifted in from `tdi` is discarded: an update strobe touches neither the word, the flag nor the chain. The TAP controller and instruction decode sit outside the block. They appear only as a select input and decoded state strobes, sampled on the rising edge of `tck`.

Top module: `dbg_tx_mailbox`

## Requirements
- R1: After reset the pending flag is 0, `ctrl_status` reads 0 and `tdo` is 0.
- R2: A core-clock write with `sw_wr_en` high loads `sw_wr_data` into the holding register and sets the pending flag. The flag is visible as `ctrl_status[28]` after that edge, and every other `ctrl_status` bit stays 0.
- R3: A capture strobe with `tap_sel` high loads the chain as follows. Bits 34 down to 3 take the holding word (word bit 0 at chain bit 3). Bit 0 takes the pending flag as seen in the TCK domain. Bits 35, 2 and 1 take 0.
- R4: Each shift strobe with `tap_sel` high moves the chain one place toward bit 0 and places `tdi` in bit 35. `tdo` always shows chain bit 0, so bit k of the snapshot appears after k shifts. A bit shifted in emerges 36 shifts later.
- R5: An update strobe changes neither the chain, the holding word nor the pending flag.
- R6: When a capture that saw the flag set is followed by a shift, the pending flag in the core domain clears within a few core cycles.
- R7: A capture that is not followed by a shift before the next capture leaves the pending flag set.
- R8: When a software write and a debugger clear reach the flag in the same core cycle, the flag stays set and the new word is kept.
- R9: With `tap_sel` low, the capture, shift and update strobes change neither the chain nor the pending flag.
- R10: A capture taken while no word is pending puts 0 in chain bit 0. Shifting that snapshot sends no clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock |
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| sw_wr_en | input | 1 | Software write strobe for the holding register |
| sw_wr_data | input | 32 | Word written by software |
| ctrl_status | output | 32 | Software-readable status; bit 28 is the pending flag |
| tap_sel | input | 1 | This data register is the one the TAP has selected |
| tap_capture | input | 1 | Capture state strobe |
| tap_shift | input | 1 | Shift state strobe |
| tap_update | input | 1 | Update state strobe |
| tdi | input | 1 | Serial data into chain bit 35 |
| tdo | output | 1 | Serial data from chain bit 0 |

## Verification
The bench sweeps a set of word patterns, including all zeros, all ones, single-bit and alternating words. For each word it reads the whole snapshot back bit by bit, which exposes a misplaced word field, a nonzero padding bit or a reversed shift direction. It then shifts again after an update to prove that the `tdi` bits come out 36 places later and that the update left everything alone. A design that clears on capture alone would fail the capture-without-shift case. A design that lets strobes through without select would lose the flag in the deselected case. The collision case keeps software writing on every core cycle while a clear is in flight, so a design that gives the clear priority drops the flag on at least one cycle.

// File: rtl/dbgtx_pkg.sv
package dbgtx_pkg;
    localparam int WORD_W     = 32;
    localparam int PAD_LO_W   = 2;
    localparam int CHAIN_W    = WORD_W + PAD_LO_W + 2;
    localparam int FLAG_BIT   = 28;
    localparam int SYNC_DEPTH = 2;

    // Bit order from MSB: pad (35), word (34:3), pad (2:1), valid (0)
    typedef struct packed {
        logic                pad_hi;
        logic [WORD_W-1:0]   word;
        logic [PAD_LO_W-1:0] pad_lo;
        logic                valid;
    } scan_frame_t;

    function automatic scan_frame_t make_frame(input logic [WORD_W-1:0] w,
                                               input logic v);
        scan_frame_t f;
        f.pad_hi = 1'b0;
        f.word   = w;
        f.pad_lo = '0;
        f.valid  = v;
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic flag);
        logic [WORD_W-1:0] s;
        s = '0;
        s[FLAG_BIT] = flag;
        return s;
    endfunction
endpackage

// File: rtl/dbgtx_sync.sv
module dbgtx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[STAGES-2:0], d};
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbgtx_hold.sv
module dbgtx_hold
    import dbgtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_pulse,
    output logic [WORD_W-1:0] word_q,
    output logic              flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en) word_q <= wr_data;
            // A write in the same cycle as a clear keeps the flag set
            if (wr_en)          flag_q <= 1'b1;
            else if (clr_pulse) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbgtx_scan.sv
module dbgtx_scan
    import dbgtx_pkg::*;
(
    input  logic               tck,
    input  logic               rst,
    input  logic               sel,
    input  logic               capture,
    input  logic               shift,
    input  logic               update,
    input  logic               tdi,
    input  logic [WORD_W-1:0]  word,
    input  logic               valid_tck,
    output logic [CHAIN_W-1:0] chain_q,
    output logic               clr_toggle
);
    typedef enum logic [1:0] {OP_IDLE, OP_CAPTURE, OP_SHIFT} scan_op_e;

    scan_op_e op;
    logic     armed_q;

    always_comb begin
        op = OP_IDLE;
        if (sel) begin
            if (capture)    op = OP_CAPTURE;
            else if (shift) op = OP_SHIFT;
        end
    end

    // Update is not decoded at all: shifted-in data is dropped
    always_ff @(posedge tck) begin
        if (rst) begin
            chain_q    <= '0;
            armed_q    <= 1'b0;
            clr_toggle <= 1'b0;
        end else begin
            case (op)
                OP_CAPTURE: begin
                    chain_q <= make_frame(word, valid_tck);
                    armed_q <= valid_tck;
                end
                OP_SHIFT: begin
                    chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
                    if (armed_q) begin
                        clr_toggle <= ~clr_toggle;
                        armed_q    <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    logic unused_update;
    assign unused_update = update;
endmodule

// File: rtl/dbg_tx_mailbox.sv
module dbg_tx_mailbox
    import dbgtx_pkg::*;
(
    input  logic              clk_core,
    input  logic              tck,
    input  logic              rst,
    input  logic              sw_wr_en,
    input  logic [WORD_W-1:0] sw_wr_data,
    output logic [WORD_W-1:0] ctrl_status,
    input  logic              tap_sel,
    input  logic              tap_capture,
    input  logic              tap_shift,
    input  logic              tap_update,
    input  logic              tdi,
    output logic              tdo
);
    logic [WORD_W-1:0]  tx_word;
    logic               flag_core;
    logic               flag_tck;
    logic [CHAIN_W-1:0] chain_q;
    logic               clr_toggle;
    logic               clr_sync;
    logic               clr_seen_q;
    logic               clr_pulse;

    dbgtx_hold u_hold (
        .clk       (clk_core),
        .rst       (rst),
        .wr_en     (sw_wr_en),
        .wr_data   (sw_wr_data),
        .clr_pulse (clr_pulse),
        .word_q    (tx_word),
        .flag_q    (flag_core)
    );

    dbgtx_sync #(.STAGES(SYNC_DEPTH)) u_flag_sync (
        .clk (tck),
        .rst (rst),
        .d   (flag_core),
        .q   (flag_tck)
    );

    dbgtx_scan u_scan (
        .tck        (tck),
        .rst        (rst),
        .sel        (tap_sel),
        .capture    (tap_capture),
        .shift      (tap_shift),
        .update     (tap_update),
        .tdi        (tdi),
        .word       (tx_word),
        .valid_tck  (flag_tck),
        .chain_q    (chain_q),
        .clr_toggle (clr_toggle)
    );

    dbgtx_sync #(.STAGES(SYNC_DEPTH)) u_clr_sync (
        .clk (clk_core),
        .rst (rst),
        .d   (clr_toggle),
        .q   (clr_sync)
    );

    always_ff @(posedge clk_core) begin
        if (rst) clr_seen_q <= 1'b0;
        else     clr_seen_q <= clr_sync;
    end

    assign clr_pulse   = clr_sync ^ clr_seen_q;
    assign ctrl_status = status_word(flag_core);
    assign tdo         = chain_q[0];
endmodule

// File: rtl/dbg_tx_mailbox_chk.sv
module dbg_tx_mailbox_chk
    import dbgtx_pkg::*;
(
    input logic               clk_core,
    input logic               tck,
    input logic               rst,
    input logic               sw_wr_en,
    input logic               tap_sel,
    input logic               tap_capture,
    input logic               tap_shift,
    input logic               tap_update,
    input logic               tdi,
    input logic [WORD_W-1:0]  tx_word,
    input logic               flag_core,
    input logic [CHAIN_W-1:0] chain_q,
    input logic               clr_pulse
);
    // R2 and R8: a write always leaves the flag set, even against a clear
    a_r2_write_sets_flag: assert property (@(posedge clk_core) disable iff (rst)
        sw_wr_en |=> flag_core);

    // R6: the flag only falls after a synchronised clear request
    a_r6_fall_needs_clear: assert property (@(posedge clk_core) disable iff (rst)
        $fell(flag_core) |-> $past(clr_pulse));

    a_r3_capture_layout: assert property (@(posedge tck) disable iff (rst)
        (tap_sel && tap_capture) |=>
            (chain_q[CHAIN_W-1] == 1'b0) && (chain_q[2:1] == 2'b00) &&
            (chain_q[CHAIN_W-2:3] == $past(tx_word)));

    a_r4_shift_step: assert property (@(posedge tck) disable iff (rst)
        (tap_sel && tap_shift && !tap_capture) |=>
            (chain_q == {$past(tdi), $past(chain_q[CHAIN_W-1:1])}));

    a_r5_update_inert: assert property (@(posedge tck) disable iff (rst)
        (tap_sel && tap_update && !tap_capture && !tap_shift) |=> $stable(chain_q));

    a_r9_deselected_inert: assert property (@(posedge tck) disable iff (rst)
        !tap_sel |=> $stable(chain_q));
endmodule

bind dbg_tx_mailbox dbg_tx_mailbox_chk u_chk (
    .clk_core    (clk_core),
    .tck         (tck),
    .rst         (rst),
    .sw_wr_en    (sw_wr_en),
    .tap_sel     (tap_sel),
    .tap_capture (tap_capture),
    .tap_shift   (tap_shift),
    .tap_update  (tap_update),
    .tdi         (tdi),
    .tx_word     (tx_word),
    .flag_core   (flag_core),
    .chain_q     (chain_q),
    .clr_pulse   (clr_pulse)
);

// File: tb/sim_dbg_tx_mailbox.sv
module sim_dbg_tx_mailbox;
    logic        clk_core = 1'b0;
    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] ctrl_status;
    logic        tap_sel = 1'b0;
    logic        tap_capture = 1'b0;
    logic        tap_shift = 1'b0;
    logic        tap_update = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5  clk_core = ~clk_core;
    always #20 tck      = ~tck;

    dbg_tx_mailbox u0 (
        .clk_core    (clk_core),
        .tck         (tck),
        .rst         (rst),
        .sw_wr_en    (sw_wr_en),
        .sw_wr_data  (sw_wr_data),
        .ctrl_status (ctrl_status),
        .tap_sel     (tap_sel),
        .tap_capture (tap_capture),
        .tap_shift   (tap_shift),
        .tap_update  (tap_update),
        .tdi         (tdi),
        .tdo         (tdo)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [35:0] frame(input logic [31:0] w, input logic v);
        return {1'b0, w, 2'b00, v};
    endfunction

    task automatic sw_write(input logic [31:0] w);
        @(negedge clk_core);
        sw_wr_en = 1'b1;
        sw_wr_data = w;
        @(negedge clk_core);
        sw_wr_en = 1'b0;
    endtask

    task automatic core_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_core);
    endtask

    task automatic tck_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge tck);
    endtask

    task automatic do_capture(input logic sel);
        @(negedge tck);
        tap_sel = sel;
        tap_capture = 1'b1;
        @(negedge tck);
        tap_capture = 1'b0;
    endtask

    task automatic do_update(input logic sel);
        @(negedge tck);
        tap_sel = sel;
        tap_update = 1'b1;
        @(negedge tck);
        tap_update = 1'b0;
    endtask

    // Called at a falling tck edge; reads tdo before each shift edge
    task automatic shift_bits(input logic sel, input logic [35:0] pat, output logic [35:0] got);
        tap_sel = sel;
        for (int i = 0; i < 36; i++) begin
            got[i] = tdo;
            tap_shift = 1'b1;
            tdi = pat[i];
            @(negedge tck);
        end
        tap_shift = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic compare_bits(input string req, input logic [35:0] got, input logic [35:0] exp);
        for (int i = 0; i < 36; i++) check(req, {63'd0, got[i]}, {63'd0, exp[i]});
    endtask

    initial begin
        logic [35:0] got;
        logic [35:0] pat;
        logic [31:0] w;
        logic [31:0] last;
        logic [31:0] words [8];
        words[0] = 32'h0000_0000; words[1] = 32'hFFFF_FFFF;
        words[2] = 32'hA5A5_A5A5; words[3] = 32'h0000_0001;
        words[4] = 32'h8000_0000; words[5] = 32'h1234_5678;
        words[6] = 32'h5A5A_5A5A; words[7] = 32'hDEAD_BEEF;

        core_wait(4);
        tck_wait(3);
        @(negedge clk_core);
        rst = 1'b0;
        tck_wait(1);
        // R1: reset state
        check("R1", {32'd0, ctrl_status}, 64'd0);
        check("R1", {63'd0, tdo}, 64'd0);

        for (int k = 0; k < 8; k++) begin
            w = words[k];
            pat = {w[3:0], ~w} ^ 36'h9_3C3C_3C3C;
            sw_write(w);
            // R2: flag at bit 28 only
            check("R2", {32'd0, ctrl_status}, 64'h1000_0000);
            tck_wait(4);
            do_capture(1'b1);
            shift_bits(1'b1, pat, got);
            compare_bits("R3", got, frame(w, 1'b1));
            do_update(1'b1);
            @(negedge tck);
            shift_bits(1'b1, 36'd0, got);
            compare_bits("R4", got, pat); // also R5: update left chain alone
            core_wait(10);
            check("R6", {32'd0, ctrl_status}, 64'd0);
            tck_wait(4);
            do_capture(1'b1);
            shift_bits(1'b1, 36'd0, got);
            compare_bits("R10", got, frame(w, 1'b0)); // word kept after update (R5)
            core_wait(10);
            check("R10", {32'd0, ctrl_status}, 64'd0);
        end

        // R7: capture without shift keeps the flag
        sw_write(32'hCAFE_F00D);
        tck_wait(4);
        do_capture(1'b1);
        do_update(1'b1);
        core_wait(12);
        check("R7", {32'd0, ctrl_status}, 64'h1000_0000);

        // R9: deselected strobes do nothing
        do_capture(1'b0);
        @(negedge tck);
        shift_bits(1'b0, 36'hF_FFFF_FFFF, got);
        do_update(1'b0);
        core_wait(12);
        check("R9", {32'd0, ctrl_status}, 64'h1000_0000);
        @(negedge tck);
        shift_bits(1'b1, 36'd0, got);
        check("R9", {28'd0, got}, {28'd0, frame(32'hCAFE_F00D, 1'b1)});
        core_wait(12);
        check("R6", {32'd0, ctrl_status}, 64'd0);

        // R8: writes every core cycle while a clear is in flight
        sw_write(32'h0BAD_0001);
        tck_wait(4);
        do_capture(1'b1);
        last = '0;
        fork
            begin
                shift_bits(1'b1, 36'd0, got);
            end
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk_core);
                    if (i > 0) check("R8", {32'd0, ctrl_status}, 64'h1000_0000);
                    sw_wr_en = 1'b1;
                    sw_wr_data = 32'h7000_0000 + i;
                    last = 32'h7000_0000 + i;
                end
                @(negedge clk_core);
                sw_wr_en = 1'b0;
            end
        join
        core_wait(12);
        check("R8", {32'd0, ctrl_status}, 64'h1000_0000);
        tck_wait(4);
        do_capture(1'b1);
        shift_bits(1'b1, 36'd0, got);
        check("R8", {28'd0, got}, {28'd0, frame(last, 1'b1)});

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk_core);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule